// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flagged Character Queue

This block recovers start-stop characters from an asynchronous serial input line. The line is sampled on a 16x bit-rate tick. The character format is chosen by four static inputs: 7 or 8 data bits, an optional even or odd parity bit, and one or two stop bits. Each character that completes is written into a 16-entry queue together with three flags of its own: parity error, framing error and break. Because the flags travel with the character, software always knows which character carried which fault.

The host drains the queue through a valid/ready read port. The head entry is offered while `rd_valid` is high, and it is consumed on a clock where both `rd_valid` and `rd_ready` are high. Back-pressure is unlimited: the entry stays unchanged for as long as `rd_ready` is low. The serial side has no back-pressure. A character that completes while the queue is full is discarded and the sticky `overrun` flag is set.

Three level-sensitive requests are derived from the queue state: queue full, an error at the head, and a break at the head. A ready-to-send output asks the far end to pause once the queue is nearly full. Configuration inputs may change only while the line is idle.

Top module: `uart_rx_flagq`

## Requirements
- R1: A start bit is recognised on a tick where the synchronised line is low while idle. It is confirmed only if the line is still low on the 8th tick after that. A low pulse shorter than this returns the receiver to idle, and no character is stored.
- R2: Data bits are taken least significant bit first, one every 16 ticks after the start confirmation. With `cfg_len8`=0 only 7 bits are received, and bit 7 of `rd_data` reads 0.
- R3: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd`=0 selects even parity, where the data bits plus the parity bit contain an even number of ones; `cfg_par_odd`=1 selects odd parity. A mismatch sets `rd_perr` for that character. With parity disabled, `rd_perr` is 0.
- R4: `rd_ferr` is set when a stop bit is sampled low. With `cfg_stop2`=1, both stop bits are checked.
- R5: `rd_brk` is set when a character has a framing error and all of its data bits, and its parity bit if one is present, are 0. After a break the receiver waits for the line to go high before it looks for a new start bit, so one held-low period yields exactly one entry.
- R6: Entries leave in arrival order. `rd_valid` is high whenever the queue is not empty. A read completes when `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_data` and the flags stay unchanged.
- R7: `irq_full` is high while 16 entries are held. `irq_err` is high while the head entry has `rd_perr` or `rd_ferr` set. `irq_brk` is high while the head entry has `rd_brk` set.
- R8: `rts` is high while the queue holds fewer than 14 entries and low while it holds 14 or more.
- R9: A character that completes while the queue holds 16 entries is discarded and `overrun` is set. `overrun` stays set until the next completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idles high |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Two stop bits expected |
| rd_valid | output | 1 | Head entry available |
| rd_ready | input | 1 | Host accepts the head entry |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_brk | output | 1 | Head break |
| irq_full | output | 1 | Queue holds 16 entries |
| irq_err | output | 1 | Head entry has parity or framing error |
| irq_brk | output | 1 | Head entry is a break |
| rts | output | 1 | High = sender may continue |
| overrun | output | 1 | Sticky: a character was discarded |

## Verification
A wrong bit counter or tick counter in the sampler shows up as wrong `rd_data`, or as a false framing error, on the next character. A lost or extra queue push shows at once as a mismatch in `rd_valid`, `rts` or `irq_full` against the expected fill level. A wrong read pointer or lost flag bit shows at the head on the read after the fault. A receiver that does not wait after a break produces extra entries within one frame time of the line going low.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_BRKW
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxs,
  input  logic      cfg_len8,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  input  logic      cfg_stop2,
  output logic      push,
  output rx_entry_t ent
);
  localparam int TW  = $clog2(OSR);
  localparam logic [TW-1:0] MID_LAST = TW'(OSR/2 - 1);
  localparam logic [TW-1:0] BIT_LAST = TW'(OSR - 1);

  rx_state_t       state;
  logic [TW-1:0]   tcnt;
  logic [2:0]      bidx;
  logic [7:0]      shreg;
  logic            parbit;
  logic            ferr_acc;

  logic [2:0]      last_idx;
  logic            at_mid;
  logic            fin_ferr;
  logic            fin_perr;
  logic            fin_brk;
  logic            fin_now;

  assign last_idx = cfg_len8 ? 3'd7 : 3'd6;
  assign at_mid   = (tcnt == BIT_LAST);
  assign fin_now  = tick && at_mid &&
                    ((state == ST_STOP2) || (state == ST_STOP1 && !cfg_stop2));
  assign fin_ferr = ferr_acc | ~rxs;
  assign fin_perr = cfg_par_en && ((^shreg ^ parbit) != cfg_par_odd);
  assign fin_brk  = fin_ferr && (shreg == 8'h00) && !(cfg_par_en && parbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      parbit   <= 1'b0;
      ferr_acc <= 1'b0;
      push     <= 1'b0;
      ent      <= '0;
    end else begin
      push <= 1'b0;
      if (fin_now) begin
        push     <= 1'b1;
        ent.data <= shreg;
        ent.perr <= fin_perr;
        ent.ferr <= fin_ferr;
        ent.brk  <= fin_brk;
        state    <= fin_brk ? ST_BRKW : ST_IDLE;
        tcnt     <= '0;
      end else if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!rxs) begin
              state <= ST_START;
              tcnt  <= '0;
            end
          end
          ST_START: begin
            if (tcnt == MID_LAST) begin
              tcnt <= '0;
              if (!rxs) begin
                state    <= ST_DATA;
                bidx     <= '0;
                shreg    <= '0;
                parbit   <= 1'b0;
                ferr_acc <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_mid) begin
              tcnt        <= '0;
              shreg[bidx] <= rxs;
              if (bidx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP1;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              tcnt   <= '0;
              parbit <= rxs;
              state  <= ST_STOP1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP1: begin
            if (at_mid) begin
              tcnt     <= '0;
              ferr_acc <= ~rxs;
              state    <= ST_STOP2;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP2: begin
            tcnt <= tcnt + 1'b1;
          end
          ST_BRKW: begin
            if (rxs) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: a confirmed start needs the line low at the confirmation tick
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(rxs));

  // R5: a break entry always leaves the receiver waiting for a high line
  assert_brk_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ent.brk) |-> (state == ST_BRKW));

  // R5: a break entry is also a framing error
  assert_brk_has_ferr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ent.brk) |-> ent.ferr);

  // R5: leaving the break wait needs a high line
  assert_brk_exit_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_BRKW && state == ST_IDLE) |-> $past(rxs));
endmodule

// File: rtl/rx_entry_fifo.sv
module rx_entry_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  rx_entry_t       wdata,
  input  logic            pop,
  output rx_entry_t       head,
  output logic [$clog2(DEPTH):0] count,
  output logic            full,
  output logic            dropped
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  rx_entry_t   mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic        do_push;
  logic        do_pop;

  assign full    = (count == CNT_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign dropped = push && full;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: a push into a full queue leaves the fill level unchanged
  assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R7: fill level never exceeds the depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  // R6: a head that is not taken stays put
  assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != '0) && !pop) |=> $stable(head));
endmodule

// File: rtl/uart_rx_flagq.sv
module uart_rx_flagq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RTS_LEVEL   = 14,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       irq_full,
  output logic       irq_err,
  output logic       irq_brk,
  output logic       rts,
  output logic       overrun
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] RTS_CNT = CW'(RTS_LEVEL);

  logic          rxs;
  logic          fr_push;
  rx_entry_t     fr_ent;
  rx_entry_t     head;
  logic [CW-1:0] count;
  logic          full;
  logic          dropped;
  logic          take;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  rx_frame_sampler #(.OSR(OSR)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxs(rxs),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .push(fr_push), .ent(fr_ent)
  );

  assign take = rd_valid && rd_ready;

  rx_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fr_push), .wdata(fr_ent),
    .pop(take), .head(head), .count(count), .full(full), .dropped(dropped)
  );

  assign rd_valid = (count != '0);
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_brk   = head.brk;
  assign irq_full = full;
  assign irq_err  = rd_valid && (head.perr || head.ferr);
  assign irq_brk  = rd_valid && head.brk;
  assign rts      = (count < RTS_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (dropped) overrun <= 1'b1;
    else if (take)    overrun <= 1'b0;
  end

  // R9: overrun only rises from a full queue
  assert_ovr_from_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(full));

  // R8: ready-to-send only drops after a character was stored
  assert_rts_falls_on_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(fr_push));

  // R6: an offered entry stays offered until taken
  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
endmodule

// File: tb/tb_uart_rx_flagq.sv
module tb_uart_rx_flagq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, irq_full, irq_err, irq_brk, rts, overrun;

  always #2.5 clk = ~clk;

  uart_rx_flagq dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .irq_full(irq_full), .irq_err(irq_err), .irq_brk(irq_brk),
    .rts(rts), .overrun(overrun)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  int tdiv     = 0;
  bit settled  = 1'b0;
  bit m_ovr    = 1'b0;
  logic [10:0] q[$];   // {brk, ferr, perr, data}

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison with the behavioural model
  always @(negedge clk) begin
    #1;
    if (settled && rst_n) begin
      chk(rd_valid == (q.size() > 0), "R6 valid", rd_valid, q.size() > 0);
      if (q.size() > 0) begin
        chk(rd_data == q[0][7:0], "R2 data", rd_data, q[0][7:0]);
        chk(rd_perr == q[0][8], "R3 perr", rd_perr, q[0][8]);
        chk(rd_ferr == q[0][9], "R4 ferr", rd_ferr, q[0][9]);
        chk(rd_brk == q[0][10], "R5 brk", rd_brk, q[0][10]);
        chk(irq_err == (q[0][8] | q[0][9]), "R7 irq_err", irq_err, q[0][8] | q[0][9]);
        chk(irq_brk == q[0][10], "R7 irq_brk", irq_brk, q[0][10]);
      end
      chk(irq_full == (q.size() == 16), "R7 irq_full", irq_full, q.size() == 16);
      chk(rts == (q.size() < 14), "R8 rts", rts, q.size() < 14);
      chk(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
    end
  end

  task automatic drive_bit(input logic v);
    @(negedge clk) rxd = v;
    repeat (63) @(negedge clk);
  endtask

  task automatic model_push(input logic [10:0] e);
    if (q.size() == 16) m_ovr = 1'b1;
    else q.push_back(e);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input bit bad_s1, input bit bad_s2);
    logic [7:0] dm;
    logic p, fe, pe, bk;
    int nb;
    settled = 1'b0;
    nb = cfg_len8 ? 8 : 7;
    dm = cfg_len8 ? d : {1'b0, d[6:0]};
    p  = (^dm) ^ cfg_par_odd ^ bad_par;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit(p);
    drive_bit(~bad_s1);
    if (cfg_stop2) drive_bit(~bad_s2);
    drive_bit(1'b1);
    drive_bit(1'b1);
    pe = cfg_par_en && bad_par;
    fe = bad_s1 || (cfg_stop2 && bad_s2);
    bk = fe && (dm == 8'h00) && !(cfg_par_en && p);
    model_push({bk, fe, pe, dm});
    settled = 1'b1;
  endtask

  task automatic read_one();
    @(negedge clk) rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (q.size() > 0) begin
      void'(q.pop_front());
      m_ovr = 1'b0;
    end
    rd_ready = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) read_one();
    repeat (3) @(negedge clk);
  endtask

  task automatic fmt(input bit l8, input bit pen, input bit podd, input bit s2);
    @(negedge clk);
    cfg_len8 = l8; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop2 = s2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    chk(rd_valid == 1'b0, "R6 reset valid", rd_valid, 0);
    chk(rts == 1'b1, "R8 reset rts", rts, 1);
    chk(irq_full == 1'b0, "R7 reset irq_full", irq_full, 0);
    chk(overrun == 1'b0, "R9 reset overrun", overrun, 0);
    settled = 1'b1;

    // R2: 8N1 clean characters, held under back-pressure (R6)
    fmt(1, 0, 0, 0);
    send_frame(8'hA5, 0, 0, 0);
    send_frame(8'h3C, 0, 0, 0);
    drain();

    // R2/R3: 7-bit even parity, bit 7 dropped
    fmt(0, 1, 0, 0);
    send_frame(8'hFF, 0, 0, 0);
    send_frame(8'h41, 1, 0, 0);  // R3 parity error, R7 irq_err at head
    drain();

    // R3: 8-bit odd parity, two stop bits
    fmt(1, 1, 1, 1);
    send_frame(8'h96, 0, 0, 0);
    send_frame(8'h07, 1, 0, 0);
    send_frame(8'h5A, 0, 0, 1);  // R4: second stop bit low
    drain();

    // R4: framing error on non-zero data
    fmt(1, 0, 0, 0);
    send_frame(8'h55, 0, 1, 0);
    // R5: all-zero framing error is a break
    send_frame(8'h00, 0, 1, 0);
    drain();

    // R5: line held low for many bit times gives a single break entry
    settled = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (20 * 64) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * 64) @(negedge clk);
    model_push({1'b1, 1'b1, 1'b0, 8'h00});
    settled = 1'b1;
    repeat (10) @(negedge clk);
    drain();

    // R1: short low pulse is rejected
    settled = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * 64) @(negedge clk);
    settled = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 glitch stored nothing", rd_valid, 0);

    // R7/R8/R9: fill, threshold, full, overrun
    for (int i = 0; i < 17; i++) begin
      send_frame(8'(8'h10 + i), 0, 0, 0);
      if (i == 12) chk(rts == 1'b1, "R8 rts at 13", rts, 1);
      if (i == 13) chk(rts == 1'b0, "R8 rts at 14", rts, 0);
      if (i == 15) chk(irq_full == 1'b1, "R7 full at 16", irq_full, 1);
    end
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    read_one();
    repeat (2) @(negedge clk);
    chk(overrun == 1'b0, "R9 overrun cleared by read", overrun, 0);
    drain();

    // R6: order after wrap
    send_frame(8'hC3, 0, 0, 0);
    send_frame(8'h81, 0, 0, 0);
    drain();

    summary();
    $finish;
  end
endmodule